// File: doc/BRIEF.md
# I/O Virtual Page Translator

This block turns the addresses that PCI-side devices use for DMA into system physical addresses. Each incoming request carries a 64-bit address. The block checks that address against a software-programmed window. An address inside the window is translated through a one-level page directory held in system memory. An address outside the window leaves the block as it came in, apart from losing its offset bits.

For a translated address, the block fetches one 8-byte directory entry over a memory read port. The entry is taken from the directory base plus eight times the 4 KiB page number. The top bit of the entry says whether the mapping is valid. A valid entry yields a read/write page address. An invalid entry yields a fault that carries no permission. Only one directory fetch is in flight at a time.

Software programs the window base (bit 0 of it enables the window), the window mask, the directory base, a purge-command word and a translation-config word. It does this through a small register port that writes either 32-bit half of a register, or both halves at once. Every register can be read back through the same port.

Top module: `iovx_top`

## Requirements
- R1: After reset every register reads back as zero, `req_ready` is 1, and both `rsp_valid` and `mem_req_valid` are 0.
- R2: When bit 0 of the base register is 0, an accepted request raises no memory read. `rsp_valid` rises on the cycle after acceptance with `rsp_addr` equal to the request address with its low 12 bits cleared, `rsp_fault`=0 and `rsp_perm_rw`=1.
- R3: When bit 0 of the base is 1 but (page address AND mask) differs from the base with bit 0 cleared, the request is passed through exactly as in R2.
- R4: When the window is enabled and matches, `mem_req_valid` rises on the cycle after acceptance with `mem_req_addr` = directory base + (request address >> 12) * 8. `req_ready` stays 0 until the response has been taken.
- R5: A returned entry with bit 63 set gives `rsp_addr` = the entry with bit 63 and bits 11:0 cleared, with `rsp_fault`=0 and `rsp_perm_rw`=1.
- R6: A returned entry with bit 63 clear gives `rsp_fault`=1, `rsp_perm_rw`=0 and `rsp_addr`=0.
- R7: Bits 11:0 of the request address have no effect on the window match, on the entry address or on the result. `rsp_addr[11:0]` is always 0.
- R8: Register select encoding: 0 base, 1 mask, 2 directory base, 3 purge command, 4 translation config. `reg_wr_strb` bit 0 writes bits 31:0 and bit 1 writes bits 63:32. A write with both strobe bits 0 changes nothing. An unused select reads 0.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response and its fields stay unchanged.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | 64 | DMA address to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_addr | output | 64 | Page-aligned result address |
| rsp_fault | output | 1 | Directory entry was invalid |
| rsp_perm_rw | output | 1 | Read/write permission granted |
| mem_req_valid | output | 1 | Directory entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry value, little-endian 64-bit |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for write and read |
| reg_wr_strb | input | 2 | Half-word enables (bit 0 low, bit 1 high) |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_data | output | 64 | Read-back of the selected register |

## Verification
A wrong walk state shows up at the ports almost at once. A wrong state either misses or duplicates the memory read on the cycle after acceptance, or raises `rsp_valid` at the wrong point, so the cycle-exact checks of `mem_req_valid` and `rsp_valid` expose it within one or two clocks. A corrupted register half or a wrong window compare shows as a wrong entry address or a wrong choice between walk and bypass on the very next request. Stalls on both handshakes show any captured value that drifts while it is held.

// File: rtl/iovx_pkg.sv
package iovx_pkg;
    localparam int WORD_W   = 64;
    localparam int HALF_W   = WORD_W / 2;
    localparam int NUM_REGS = 5;
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_BASE  = 3'd0,
        SEL_MASK  = 3'd1,
        SEL_DIR   = 3'd2,
        SEL_PURGE = 3'd3,
        SEL_CFG   = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MREQ,
        ST_MWAIT,
        ST_RESP
    } walk_st_e;
endpackage

// File: rtl/iovx_regs.sv
module iovx_regs
    import iovx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     sel,
    input  logic [1:0]           wr_strb,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [WORD_W-1:0]    rd_data,
    output logic [WORD_W-1:0]    base,
    output logic [WORD_W-1:0]    mask,
    output logic [WORD_W-1:0]    dir_base
);
    typedef struct packed {
        logic [NUM_REGS-1:0][WORD_W-1:0] r;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && sel == SEL_W'(i)) begin
                if (wr_strb[0]) regs_d.r[i][HALF_W-1:0]      = wr_data[HALF_W-1:0];
                if (wr_strb[1]) regs_d.r[i][WORD_W-1:HALF_W] = wr_data[WORD_W-1:HALF_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel == SEL_W'(i)) rd_data = regs_q.r[i];
        end
    end

    assign base     = regs_q.r[SEL_BASE];
    assign mask     = regs_q.r[SEL_MASK];
    assign dir_base = regs_q.r[SEL_DIR];

    // R8: a write with no half enabled leaves every register unchanged
    a_r8_no_strb_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb == 2'b00) |=> $stable(regs_q));

    // R8: writing only the low half leaves the high half unchanged
    a_r8_low_half_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb == 2'b01 && sel == SEL_MASK) |=> $stable(mask[WORD_W-1:HALF_W]));
endmodule

// File: rtl/iovx_match.sv
module iovx_match
    import iovx_pkg::*;
#(
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic [WORD_W-1:0] page_addr,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] mask,
    input  logic [WORD_W-1:0] dir_base,
    output logic              hit,
    output logic [WORD_W-1:0] entry_addr
);
    localparam logic [WORD_W-1:0] ENABLE_BIT = WORD_W'(1);

    logic [WORD_W-1:0] page_index;

    assign hit        = base[0] && ((page_addr & mask) == (base & ~ENABLE_BIT));
    assign page_index = page_addr >> PAGE_SHIFT;
    assign entry_addr = dir_base + (page_index << ENTRY_SHIFT);
endmodule

// File: rtl/iovx_walk.sv
module iovx_walk
    import iovx_pkg::*;
#(
    parameter int PAGE_SHIFT = 12,
    parameter int VALID_BIT  = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] page_addr,
    input  logic              hit,
    input  logic [WORD_W-1:0] entry_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_addr,
    output logic              rsp_fault,
    output logic              rsp_perm_rw,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [WORD_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data
);
    localparam logic [WORD_W-1:0] OFFSET_MASK = (WORD_W'(1) << PAGE_SHIFT) - WORD_W'(1);
    localparam logic [WORD_W-1:0] VALID_MASK  = WORD_W'(1) << VALID_BIT;

    typedef struct packed {
        walk_st_e          st;
        logic [WORD_W-1:0] mem_addr;
        logic [WORD_W-1:0] out_addr;
        logic              fault;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.fault = 1'b0;
                    if (hit) begin
                        w_d.st       = ST_MREQ;
                        w_d.mem_addr = entry_addr;
                        w_d.out_addr = '0;
                    end else begin
                        w_d.st       = ST_RESP;
                        w_d.out_addr = page_addr;
                    end
                end
            end
            ST_MREQ: begin
                if (mem_req_ready) w_d.st = ST_MWAIT;
            end
            ST_MWAIT: begin
                if (mem_rsp_valid) begin
                    w_d.st = ST_RESP;
                    if (mem_rsp_data[VALID_BIT]) begin
                        w_d.out_addr = mem_rsp_data & ~VALID_MASK & ~OFFSET_MASK;
                        w_d.fault    = 1'b0;
                    end else begin
                        w_d.out_addr = '0;
                        w_d.fault    = 1'b1;
                    end
                end
            end
            ST_RESP: begin
                if (rsp_ready) w_d.st = ST_IDLE;
            end
            default: w_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '{st: ST_IDLE, mem_addr: '0, out_addr: '0, fault: 1'b0};
        else        w_q <= w_d;
    end

    assign req_ready     = (w_q.st == ST_IDLE);
    assign mem_req_valid = (w_q.st == ST_MREQ);
    assign mem_req_addr  = w_q.mem_addr;
    assign rsp_valid     = (w_q.st == ST_RESP);
    assign rsp_addr      = w_q.out_addr;
    assign rsp_fault     = w_q.fault;
    assign rsp_perm_rw   = ~w_q.fault;

    // R10: a stalled memory read keeps its request and address
    a_r10_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: a stalled response keeps every field
    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_addr) && $stable(rsp_fault)));

    // R6: a fault never carries permission or an address
    a_r6_fault_noperm: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_perm_rw && rsp_addr == '0));

    // R5: a valid entry leads to a non-faulting response
    a_r5_valid_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == ST_MWAIT && mem_rsp_valid && mem_rsp_data[VALID_BIT]) |=>
            (rsp_valid && !rsp_fault && rsp_perm_rw));
endmodule

// File: rtl/iovx_top.sv
module iovx_top
    import iovx_pkg::*;
#(
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 3,
    parameter int VALID_BIT   = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_addr,
    output logic              rsp_fault,
    output logic              rsp_perm_rw,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_sel,
    input  logic [1:0]        reg_wr_strb,
    input  logic [63:0]       reg_wr_data,
    output logic [63:0]       reg_rd_data
);
    localparam logic [WORD_W-1:0] OFFSET_MASK = (WORD_W'(1) << PAGE_SHIFT) - WORD_W'(1);

    logic [WORD_W-1:0] base, mask, dir_base, page_addr, entry_addr;
    logic              hit;

    assign page_addr = req_addr & ~OFFSET_MASK;

    iovx_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .sel      (reg_sel),
        .wr_strb  (reg_wr_strb),
        .wr_data  (reg_wr_data),
        .rd_data  (reg_rd_data),
        .base     (base),
        .mask     (mask),
        .dir_base (dir_base)
    );

    iovx_match #(.PAGE_SHIFT(PAGE_SHIFT), .ENTRY_SHIFT(ENTRY_SHIFT)) u_match (
        .page_addr  (page_addr),
        .base       (base),
        .mask       (mask),
        .dir_base   (dir_base),
        .hit        (hit),
        .entry_addr (entry_addr)
    );

    iovx_walk #(.PAGE_SHIFT(PAGE_SHIFT), .VALID_BIT(VALID_BIT)) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .page_addr     (page_addr),
        .hit           (hit),
        .entry_addr    (entry_addr),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_addr      (rsp_addr),
        .rsp_fault     (rsp_fault),
        .rsp_perm_rw   (rsp_perm_rw),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // R2, R3: a request outside the window is answered on the next cycle with no memory read
    a_r2_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hit) |=> (rsp_valid && !mem_req_valid && !rsp_fault));

    // R4: a request inside the window starts exactly one entry read at the computed address
    a_r4_walk_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit) |=>
            (mem_req_valid && !rsp_valid && mem_req_addr == $past(entry_addr)));

    // R4: no new request is taken while a walk is in flight
    a_r4_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R7: results are always page aligned
    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_addr[PAGE_SHIFT-1:0] == '0));
endmodule

// File: tb/sim_iovx_top.sv
module sim_iovx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, rsp_ready = 1'b1, mem_req_ready = 1'b1;
    logic        mem_rsp_valid = 1'b0, reg_wr_en = 1'b0;
    logic [63:0] req_addr = '0, mem_rsp_data = '0, reg_wr_data = '0;
    logic [2:0]  reg_sel = '0;
    logic [1:0]  reg_wr_strb = '0;
    logic        req_ready, rsp_valid, rsp_fault, rsp_perm_rw, mem_req_valid;
    logic [63:0] rsp_addr, mem_req_addr, reg_rd_data;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    iovx_top u0 (.*);

    typedef struct packed {
        logic [63:0] base, mask, dir, addr, entry;
        logic        walk;
        logic [63:0] exp_mem, exp_addr;
        logic        fault;
    } vec_t;

    localparam vec_t VECS [6] = '{
        // R2: window disabled
        '{64'h0, 64'h0, 64'h8000_0000, 64'h1234_5ABC, 64'h0, 1'b0, 64'h0, 64'h1234_5000, 1'b0},
        // R5: hit, valid entry
        '{64'h4000_0001, 64'hFFFF_FFFF_C000_0000, 64'h8000_0000, 64'h4000_3123,
          64'h8000_00AB_CDEF_1FFF, 1'b1, 64'h8020_0018, 64'h0000_00AB_CDEF_1000, 1'b0},
        // R3: enabled, mismatch
        '{64'h4000_0001, 64'hFFFF_FFFF_C000_0000, 64'h8000_0000, 64'h8000_0000,
          64'h0, 1'b0, 64'h0, 64'h8000_0000, 1'b0},
        // R6: hit, invalid entry
        '{64'h4000_0001, 64'hFFFF_FFFF_C000_0000, 64'h8000_0000, 64'h4000_0FFF,
          64'h0000_0000_1234_5000, 1'b1, 64'h8020_0000, 64'h0, 1'b1},
        // R5: upper-half window, all-ones entry
        '{64'h0000_0010_0000_0001, 64'hFFFF_FFF0_0000_0000, 64'h8000_0000, 64'h0000_0010_0000_2456,
          64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h8800_0010, 64'h7FFF_FFFF_FFFF_F000, 1'b0},
        // R2: enable bit clear though the window would match
        '{64'h4000_0000, 64'hFFFF_FFFF_C000_0000, 64'h8000_0000, 64'h4000_3123,
          64'h0, 1'b0, 64'h0, 64'h4000_3000, 1'b0}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [1:0] st, input logic [63:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wr_strb = st; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wr_strb = 2'b00;
    endtask

    task automatic rd(input logic [2:0] s, output logic [63:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rd_data;
    endtask

    // Issue one request; memory answers immediately; both handshakes ready.
    task automatic run_req(input vec_t v, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = v.addr;
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req_valid === v.walk, {tag, " walk/bypass"}, 64'(mem_req_valid), 64'(v.walk));
        if (v.walk) begin
            check(mem_req_addr === v.exp_mem, "R4 entry address", mem_req_addr, v.exp_mem);
            @(negedge clk);
            mem_rsp_valid = 1'b1; mem_rsp_data = v.entry;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
        check(rsp_valid === 1'b1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check(rsp_addr === v.exp_addr, {tag, " rsp_addr"}, rsp_addr, v.exp_addr);
        check(rsp_fault === v.fault, {tag, " rsp_fault"}, 64'(rsp_fault), 64'(v.fault));
        check(rsp_perm_rw === !v.fault, {tag, " rsp_perm_rw"}, 64'(rsp_perm_rw), 64'(!v.fault));
        @(negedge clk);
        check(rsp_valid === 1'b0 && req_ready === 1'b1, {tag, " back to idle"},
              64'({rsp_valid, req_ready}), 64'b01);
    endtask

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R1 no valid",
              64'({rsp_valid, mem_req_valid}), 64'd0);
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), d);
            check(d === 64'h0, "R1 register zero", d, 64'h0);
        end

        // Vector table
        for (int k = 0; k < 6; k++) begin
            wr(3'd0, 2'b11, VECS[k].base);
            wr(3'd1, 2'b11, VECS[k].mask);
            wr(3'd2, 2'b11, VECS[k].dir);
            run_req(VECS[k], VECS[k].walk ? (VECS[k].fault ? "R6" : "R5") : "R2/R3");
        end

        // R7: offset bits have no effect (same page as vector 1, different offset)
        begin
            vec_t v = VECS[1];
            wr(3'd0, 2'b11, v.base); wr(3'd1, 2'b11, v.mask); wr(3'd2, 2'b11, v.dir);
            v.addr = 64'h4000_3000;
            run_req(v, "R7");
        end

        // R8: half writes, strobe-free write, purge/config, unused select
        wr(3'd1, 2'b11, 64'h0);
        wr(3'd1, 2'b01, 64'h1111_2222_AAAA_BBBB);
        rd(3'd1, d);
        check(d === 64'h0000_0000_AAAA_BBBB, "R8 low half", d, 64'h0000_0000_AAAA_BBBB);
        wr(3'd1, 2'b10, 64'h5555_6666_0000_0000);
        rd(3'd1, d);
        check(d === 64'h5555_6666_AAAA_BBBB, "R8 high half", d, 64'h5555_6666_AAAA_BBBB);
        wr(3'd1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(3'd1, d);
        check(d === 64'h5555_6666_AAAA_BBBB, "R8 no strobe", d, 64'h5555_6666_AAAA_BBBB);
        wr(3'd3, 2'b11, 64'hDEAD_BEEF_0000_0001);
        rd(3'd3, d);
        check(d === 64'hDEAD_BEEF_0000_0001, "R8 purge", d, 64'hDEAD_BEEF_0000_0001);
        wr(3'd4, 2'b01, 64'h0000_0000_0000_00C3);
        rd(3'd4, d);
        check(d === 64'hC3, "R8 config", d, 64'hC3);
        wr(3'd7, 2'b11, 64'h1234);
        rd(3'd7, d);
        check(d === 64'h0, "R8 unused select", d, 64'h0);

        // R10 / R9: stall both handshakes
        wr(3'd0, 2'b11, VECS[1].base); wr(3'd1, 2'b11, VECS[1].mask); wr(3'd2, 2'b11, VECS[1].dir);
        mem_req_ready = 1'b0; rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = VECS[1].addr;
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check(mem_req_valid === 1'b1 && mem_req_addr === VECS[1].exp_mem,
                  "R10 request held", mem_req_addr, VECS[1].exp_mem);
            check(req_ready === 1'b0, "R4 busy blocks new request", 64'(req_ready), 64'd0);
        end
        req_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = VECS[1].entry;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        for (int c = 0; c < 3; c++) begin
            check(rsp_valid === 1'b1 && rsp_addr === VECS[1].exp_addr,
                  "R9 response held", rsp_addr, VECS[1].exp_addr);
            @(negedge clk);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R9 released", 64'(rsp_valid), 64'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule